// File: doc/BRIEF.md
# Indirect-Access Memory Controller Register Block

This block is the configuration slave of a DDR2 memory controller. A processor reaches it over a simple control-register bus that carries a register number, separate read and write strobes, and 32-bit data. Most controller settings are not directly addressed. Software first loads an index into a pointer register, then reads or writes through a data window. A few indices return fixed status words. One index holds the option word, and bit 27 of that word is the controller enable.

Each bank has a size, counted in 8 MiB units, and a physical base, given as address bits 33:23. Both come in on static input ports. The block presents each bank to the bus as a read-only descriptor. Banks are armed only when the enable bit rises and disarmed only when it falls. At that rising edge the block records which banks are populated. From the armed banks it raises a registered, one-hot hit flag for the incoming physical address.

Top module: `ddr_regblk`

## Requirements
- R1: Register number 0x10 is the index pointer. A write stores all 32 bits, and a read returns that value unchanged.
- R2: Read data and the acknowledge both appear on the cycle after the strobe. Acknowledge is pulsed for every read or write of a claimed number, meaning 0x10, 0x11, 0x40 to 0x43, and the inert numbers. Any other number gets no acknowledge and reads back zero data.
- R3: Reads through the data window (number 0x11) return fixed words. Index 0x14 and index 0x1F both return 0x80000000, index 0x40 returns 0x00008001, and index 0x7A returns 0x02000000. Every other index except 0x21 reads zero. Writes through the window to any index other than 0x21 change nothing.
- R4: Index 0x21 is the option word. Only bit 27, the controller enable, is kept. Reading the option word returns 0x08000000 when the controller is enabled and 0 when it is not.
- R5: Writing a 1 to bit 27 while the controller is disabled arms exactly the banks that are populated at that moment. A bank that becomes populated later stays unarmed until the next rising edge of the enable bit.
- R6: Writing a 0 to bit 27 while the controller is enabled disarms every bank. Writing the enable state that is already held changes nothing.
- R7: Register numbers 0x40+i return the descriptor of bank i. Writes to these numbers are ignored. A bank that is unpopulated, or that lies beyond the configured bank count, reads zero.
- R8: A descriptor is built from the bank's fields as follows:
  - bits 31:21 hold the base address bits 33:23;
  - bits 15:6 hold 1024 minus the size in 8 MiB units;
  - bit 0 is 1;
  - all other bits are 0.
  A bank is populated only when its size is a power of two from 1 to 512 units. Any other size, including 0, gives an all-zero descriptor.
- R9: Register numbers 0x45, 0x4A, 0x4B, 0x4F and 0x50 read zero and ignore writes.
- R10: hit_o[i] is a register. It is updated on the edge after the address is presented. It is set when bank i is armed and populated and the address bits 33:23, with the low log2(size) bits cleared, equal the bank's base bits. When several banks match, only the lowest-numbered one is flagged.
- R11: While the controller is disabled, no hit bit is ever set.
- R12: Synchronous reset clears the index pointer, the enable bit and all armed flags. It also clears the hit, read data and acknowledge outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_num_i | input | NUM_W | Register number for the current access |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid along with the acknowledge |
| reg_ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| bank_base_i | input | NUM_BANKS x 11 | Base address bits 33:23 for each bank |
| bank_units_i | input | NUM_BANKS x 10 | Size of each bank in 8 MiB units |
| phys_page_i | input | 11 | Physical address bits 33:23 to match |
| hit_o | output | NUM_BANKS | Registered one-hot bank hit |

## Verification
An address lookup and an enable-bit write can fall in the same clock edge. The bench provokes this by presenting an address inside bank 0 on the same cycle as the write that raises bit 27. It then checks that the hit output stays clear after that edge, because the hit is computed from the old armed state, and that the hit appears one edge later. The disarming write is not overlapped with a lookup this way; each disarm is followed by a full address sweep that must show no hits. Snapshot behaviour is tested by populating a bank while the controller is enabled and confirming that the bank stays silent until the enable bit is cleared and set again.

// File: rtl/ddr_regblk_pkg.sv
package ddr_regblk_pkg;
  localparam int PA_W    = 34;               // physical address width
  localparam int UNIT_SH = 23;               // 8 MiB granule
  localparam int PG_W    = PA_W - UNIT_SH;   // page bits compared
  localparam int SZ_W    = 10;               // size field width
  localparam int DW      = 32;
  localparam int MAX_BANKS = 4;

  localparam int RN_INDEX = 'h10;
  localparam int RN_DATA  = 'h11;
  localparam int RN_BANK0 = 'h40;

  localparam logic [DW-1:0] IX_OPT    = 32'h21;
  localparam int            EN_BIT    = 27;

  function automatic logic is_inert(input int n);
    return (n == 'h45) || (n == 'h4A) || (n == 'h4B) || (n == 'h4F) || (n == 'h50);
  endfunction

  function automatic logic [DW-1:0] fixed_view(input logic [DW-1:0] ix);
    case (ix)
      32'h14, 32'h1F: return 32'h8000_0000;
      32'h40:         return 32'h0000_8001;
      32'h7A:         return 32'h0200_0000;
      default:        return '0;
    endcase
  endfunction
endpackage

// File: rtl/ddr_bank_desc.sv
module ddr_bank_desc
  import ddr_regblk_pkg::*;
(
  input  logic [PG_W-1:0] base_i,
  input  logic [SZ_W-1:0] units_i,
  input  logic [PG_W-1:0] page_i,
  output logic [DW-1:0]   desc_o,
  output logic            populated_o,
  output logic            match_o
);
  logic [SZ_W-1:0] size_field;
  logic [PG_W-1:0] page_mask;

  always_comb begin
    populated_o = (units_i != '0) && ((units_i & (units_i - 1'b1)) == '0);
    size_field  = SZ_W'((SZ_W+1)'(1 << SZ_W) - {1'b0, units_i});
    page_mask   = ~{1'b0, units_i - 1'b1};
    desc_o      = populated_o ? {base_i, 5'b0, size_field, 5'b0, 1'b1} : '0;
    match_o     = populated_o && ((page_i & page_mask) == base_i);
  end
endmodule

// File: rtl/ddr_opt_ctrl.sv
module ddr_opt_ctrl #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opt_wr_i,
  input  logic          en_bit_i,
  input  logic [NB-1:0] populated_i,
  output logic          en_o,
  output logic [NB-1:0] active_o
);
  logic          en_q;
  logic [NB-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      active_q <= '0;
    end else if (opt_wr_i) begin
      if (!en_q && en_bit_i) begin
        en_q     <= 1'b1;
        active_q <= populated_i;
      end else if (en_q && !en_bit_i) begin
        en_q     <= 1'b0;
        active_q <= '0;
      end
    end
  end

  assign en_o     = en_q;
  assign active_o = active_q;

  // R5
  arm_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> active_q == $past(populated_i));
  // R6
  disarm_all_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> active_q == '0);
  // R6
  same_state_chk: assert property (@(posedge clk) disable iff (rst)
    (opt_wr_i && (en_bit_i == en_q)) |=> $stable(active_q));
endmodule

// File: rtl/ddr_hit_sel.sv
module ddr_hit_sel #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] cand_i,
  output logic [NB-1:0] hit_o
);
  logic [NB-1:0] pick;
  logic [NB-1:0] hit_q;

  always_comb begin
    pick = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (cand_i[i]) pick = NB'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= pick;
  end

  assign hit_o = hit_q;

  // R10
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_q));
endmodule

// File: rtl/ddr_regblk.sv
module ddr_regblk
  import ddr_regblk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_W     = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_W-1:0]                reg_num_i,
  input  logic                            reg_rd_i,
  input  logic                            reg_wr_i,
  input  logic [31:0]                     reg_wdata_i,
  output logic [31:0]                     reg_rdata_o,
  output logic                            reg_ack_o,
  input  logic [NUM_BANKS-1:0][10:0]      bank_base_i,
  input  logic [NUM_BANKS-1:0][9:0]       bank_units_i,
  input  logic [10:0]                     phys_page_i,
  output logic [NUM_BANKS-1:0]            hit_o
);
  localparam logic [NUM_W-1:0] N_INDEX = NUM_W'(RN_INDEX);
  localparam logic [NUM_W-1:0] N_DATA  = NUM_W'(RN_DATA);
  localparam logic [NUM_W-1:0] N_BLO   = NUM_W'(RN_BANK0);
  localparam logic [NUM_W-1:0] N_BHI   = NUM_W'(RN_BANK0 + MAX_BANKS - 1);

  logic [DW-1:0]        idx_q;
  logic [DW-1:0]        rdata_q;
  logic                 ack_q;
  logic [DW-1:0]        desc   [NUM_BANKS];
  logic [NUM_BANKS-1:0] populated;
  logic [NUM_BANKS-1:0] match;
  logic [NUM_BANKS-1:0] active;
  logic                 en;
  logic                 claimed;
  logic                 opt_wr;
  logic [DW-1:0]        rd_val;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_desc u_desc (
      .base_i      (bank_base_i[b]),
      .units_i     (bank_units_i[b]),
      .page_i      (phys_page_i),
      .desc_o      (desc[b]),
      .populated_o (populated[b]),
      .match_o     (match[b])
    );
  end

  assign opt_wr = reg_wr_i && (reg_num_i == N_DATA) && (idx_q == IX_OPT);

  ddr_opt_ctrl #(.NB(NUM_BANKS)) u_opt (
    .clk         (clk),
    .rst         (rst),
    .opt_wr_i    (opt_wr),
    .en_bit_i    (reg_wdata_i[EN_BIT]),
    .populated_i (populated),
    .en_o        (en),
    .active_o    (active)
  );

  ddr_hit_sel #(.NB(NUM_BANKS)) u_hit (
    .clk    (clk),
    .rst    (rst),
    .cand_i (match & active),
    .hit_o  (hit_o)
  );

  always_comb begin
    claimed = (reg_num_i == N_INDEX) || (reg_num_i == N_DATA) ||
              ((reg_num_i >= N_BLO) && (reg_num_i <= N_BHI)) ||
              is_inert(int'(reg_num_i));
    rd_val = '0;
    if (reg_num_i == N_INDEX) begin
      rd_val = idx_q;
    end else if (reg_num_i == N_DATA) begin
      if (idx_q == IX_OPT) rd_val = DW'({en, EN_BIT'(0)});
      else                 rd_val = fixed_view(idx_q);
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (reg_num_i == NUM_W'(RN_BANK0 + b)) rd_val = desc[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      if (reg_wr_i && (reg_num_i == N_INDEX)) idx_q <= reg_wdata_i;
      rdata_q <= (reg_rd_i && claimed) ? rd_val : '0;
      ack_q   <= (reg_rd_i || reg_wr_i) && claimed;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign reg_ack_o   = ack_q;

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    reg_ack_o |-> $past(reg_rd_i || reg_wr_i));
  // R2
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_ack_o |-> reg_rdata_o == '0);
  // R11
  hit_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o != '0) |-> $past(en));
endmodule

// File: tb/sim_ddr_regblk.sv
module sim_ddr_regblk;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [9:0]        reg_num = '0;
  logic              reg_rd = 1'b0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              reg_ack;
  logic [NB-1:0][10:0] bases;
  logic [NB-1:0][9:0]  units;
  logic [10:0]       page = '0;
  logic [NB-1:0]     hit;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit en_m = 0;
  bit [NB-1:0] act_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_regblk #(.NUM_BANKS(NB), .NUM_W(10)) u0 (
    .clk(clk), .rst(rst), .reg_num_i(reg_num), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_ack_o(reg_ack),
    .bank_base_i(bases), .bank_units_i(units), .phys_page_i(page), .hit_o(hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pow2(input int n);
    for (int k = 0; k < 10; k++) if (n == (1 << k)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] e_desc(input int pg, input int n);
    if (!pow2(n)) return 32'h0;
    return (32'(pg) << 21) | (32'(1024 - n) << 6) | 32'h1;
  endfunction

  function automatic logic [NB-1:0] e_hit(input int a);
    for (int i = 0; i < NB; i++) begin
      int n = int'(units[i]);
      if (en_m && act_m[i] && pow2(n) && ((a - (a % n)) == int'(bases[i])))
        return NB'(1) << i;
    end
    return '0;
  endfunction

  task automatic rd(input int n, output logic [31:0] d, output logic a);
    reg_num = 10'(n); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata; a = reg_ack;
  endtask

  task automatic wr(input int n, input logic [31:0] v, output logic a);
    reg_num = 10'(n); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; a = reg_ack;
  endtask

  task automatic set_en(input bit v);
    logic a;
    wr('h10, 32'h21, a);
    wr('h11, v ? 32'hFFFF_FFFF : 32'h0, a);
    if (v && !en_m) begin
      en_m = 1;
      for (int i = 0; i < NB; i++) act_m[i] = pow2(int'(units[i]));
    end else if (!v && en_m) begin
      en_m = 0; act_m = '0;
    end
  endtask

  task automatic sweep_hit(input string req);
    for (int a = 0; a < 2048; a++) begin
      page = 11'(a);
      @(negedge clk);
      chk(req, 32'(hit), 32'(e_hit(a)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic a;
    bases[0] = 11'd0;   units[0] = 10'd1;
    bases[1] = 11'd2;   units[1] = 10'd2;
    bases[2] = 11'd128; units[2] = 10'd3;
    bases[3] = 11'd1024; units[3] = 10'd512;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 hit", 32'(hit), 0);
    rd('h10, d, a); chk("R12 index", d, 0); chk("R2 ack", 32'(a), 1);
    wr('h10, 32'h21, a);
    rd('h11, d, a); chk("R12 option", d, 0);

    // R1 index store and readback
    foreach (d[i]) begin
      wr('h10, 32'h1 << i | 32'hA500_0000, a); chk("R2 wr ack", 32'(a), 1);
      rd('h10, d, a); chk("R1 index", d, 32'h1 << i | 32'hA500_0000);
    end

    // R3 fixed views and ignored writes
    wr('h10, 32'h14, a); rd('h11, d, a); chk("R3 0x14", d, 32'h8000_0000);
    wr('h10, 32'h1F, a); rd('h11, d, a); chk("R3 0x1F", d, 32'h8000_0000);
    wr('h10, 32'h40, a); wr('h11, 32'h1234, a); rd('h11, d, a); chk("R3 0x40", d, 32'h0000_8001);
    wr('h10, 32'h7A, a); rd('h11, d, a); chk("R3 0x7A", d, 32'h0200_0000);
    wr('h10, 32'hE1, a); rd('h11, d, a); chk("R3 unknown", d, 0);
    wr('h10, 32'h121, a); wr('h11, 32'hFFFF_FFFF, a); rd('h11, d, a); chk("R3 unknown wr", d, 0);
    wr('h10, 32'h21, a); rd('h11, d, a); chk("R3 option untouched", d, 0);

    // R9 inert numbers, R2 unclaimed numbers
    foreach (bases[i]) begin end
    for (int k = 0; k < 5; k++) begin
      int n = (k == 0) ? 'h45 : (k == 1) ? 'h4A : (k == 2) ? 'h4B : (k == 3) ? 'h4F : 'h50;
      wr(n, 32'hFFFF_FFFF, a); chk("R9 wr ack", 32'(a), 1);
      rd(n, d, a); chk("R9 read", d, 0); chk("R9 rd ack", 32'(a), 1);
    end
    rd('h12, d, a); chk("R2 unclaimed ack", 32'(a), 0); chk("R2 unclaimed data", d, 0);
    wr('h44, 32'h1, a); chk("R2 unclaimed wr ack", 32'(a), 0);

    // R7 bank registers, writes ignored
    for (int i = 0; i < NB; i++) begin
      wr('h40 + i, 32'h0, a);
      rd('h40 + i, d, a);
      chk("R7 bank read", d, e_desc(int'(bases[i]), int'(units[i])));
    end

    // R8 size sweep and base sweep on bank 0
    for (int n = 0; n < 1024; n++) begin
      units[0] = 10'(n);
      rd('h40, d, a); chk("R8 size", d, e_desc(int'(bases[0]), n));
    end
    units[0] = 10'd1;
    for (int p = 0; p < 2048; p += 7) begin
      bases[0] = 11'(p);
      rd('h40, d, a); chk("R8 base", d, e_desc(p, 1));
    end
    bases[0] = 11'd0;

    // R11 disabled: no hits
    sweep_hit("R11 disabled");

    // R4 option word keeps only the enable bit; R5 arming
    set_en(1);
    rd('h11, d, a); chk("R4 option", d, 32'h0800_0000);
    sweep_hit("R10 enabled");

    // R10 overlap priority
    bases[1] = 11'd0;
    sweep_hit("R10 priority");
    bases[1] = 11'd2;

    // R5 bank populated after the edge stays unarmed
    units[2] = 10'd4;
    sweep_hit("R5 late bank");
    set_en(1);
    sweep_hit("R6 same state");
    rd('h11, d, a); chk("R6 option", d, 32'h0800_0000);

    // R6 disarm
    set_en(0);
    rd('h11, d, a); chk("R4 option off", d, 0);
    sweep_hit("R6 disabled");
    set_en(0);
    sweep_hit("R6 same off");

    // Enable write and lookup in the same cycle
    wr('h10, 32'h21, a);
    page = 11'd0;
    reg_num = 10'h11; reg_wdata = 32'h0800_0000; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 same cycle old", 32'(hit), 0);
    en_m = 1; for (int i = 0; i < NB; i++) act_m[i] = pow2(int'(units[i]));
    @(negedge clk);
    chk("R10 same cycle new", 32'(hit), 32'h1);
    sweep_hit("R5 rearm");

    // R12 reset mid-run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    en_m = 0; act_m = '0;
    page = 11'd0;
    @(negedge clk);
    chk("R12 hit after reset", 32'(hit), 0);
    rd('h10, d, a); chk("R12 index after reset", d, 0);
    wr('h10, 32'h21, a);
    rd('h11, d, a); chk("R12 option after reset", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule